// File: doc/BRIEF.md
# Background Sampler Offset Trimming Controller

This controller trims the offset-cancel code of each data and edge sampler in a serial receiver while live traffic keeps flowing. A spare monitor sampler stands in for one working sampler at a time. The controller selects that sampler through an output-substitution control. It then exchanges the monitor's 9-bit reference-level code with the selected sampler's share of the 8-bit threshold code, so the trim also absorbs residual threshold error. Finally it forces the sampler input to the reference and searches for the 5-bit offset code at which the comparator output flips.

One pulse on the start input walks every sampler once, in ascending index order. For each sampler the controller settles the output swap for a set number of cycles. It then runs a binary search, most significant bit first. Each bit decision is a majority vote over a configurable number of comparator samples. The controller writes the result into that sampler's code register, then drops the swap for at least one cycle before it moves to the next sampler. A one-cycle done pulse follows the last sampler. An abort input returns every swap to normal on the next clock edge and throws away the code still being searched.

Top module: `sampcal_seq`

## Requirements
- R1: While reset is high and just after it, sub_en_o, thr_swap_o, force_ref_o, busy_o and done_o are 0 and every offset code reads mid-scale (16 for 5 bits).
- R2: A start pulse taken while idle calibrates samplers 0, 1, ..., NUM_SAMP-1 in that order, each exactly once. A start pulse while busy_o is high is ignored.
- R3: For each sampler, sub_en_o is high with sub_sel_o equal to its index for exactly SETTLE_CYC cycles before force_ref_o rises.
- R4: While force_ref_o is high, thr_swap_o and sub_en_o are high. The selected sampler's slice of ofs_code_o carries the trial code, and all other slices carry their stored codes.
- R5: The search sets and tests bits from the MSB down. A comparator result of 1 means the trial is too high and clears the tested bit. With a comparator that reports 1 exactly when code > T, the stored result equals T, including T = 0 and T = 31.
- R6: Each bit decision takes VOTES consecutive comparator samples. The bit is cleared when more than half of them are 1, so a minority of wrong samples does not change the result.
- R7: Comparator inputs of samplers that are not selected have no effect. sub_en_o is low for at least one cycle between two samplers.
- R8: After the last sampler's swap is released, done_o is high for exactly one cycle with busy_o low.
- R9: When abort_i is high at a clock edge, sub_en_o, thr_swap_o, force_ref_o and busy_o are all low after that edge, and no done_o pulse follows. Codes already committed are kept.
- R10: If abort_i coincides with the final bit decision of a sampler, the abort wins and that sampler's stored code keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one calibration round |
| abort_i | input | 1 | Cancel the round and release all swaps |
| cmp_i | input | NUM_SAMP | Comparator output of each sampler |
| ofs_code_o | output | NUM_SAMP*OFS_W | Offset-cancel code of each sampler, sampler 0 in the low bits |
| sub_en_o | output | 1 | Monitor sampler carries the selected sampler's output |
| sub_sel_o | output | $clog2(NUM_SAMP) | Index of the selected sampler |
| thr_swap_o | output | 1 | Reference code swapped with the selected sampler's threshold |
| force_ref_o | output | 1 | Selected sampler's input tied to the reference |
| busy_o | output | 1 | A round is in progress |
| done_o | output | 1 | One-cycle pulse when a round completes |

## Verification
Two events can land in the same cycle: the commit of a sampler's final search bit and an abort. The bench waits for force_ref_o to rise and counts 24 further cycles. That makes the 25th vote (5 bits of 5 votes) the one sampled on the edge where abort_i is high. It then confirms that all swaps are released and that the sampler's code still holds the value from the previous round rather than the new target. A second abort, issued during the middle sampler, confirms that codes committed before the abort are kept.

// File: rtl/sampcal_pkg.sv
package sampcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEARCH,
        ST_RESTORE
    } cal_state_e;

    typedef struct packed {
        logic out_swap;
        logic ref_swap;
        logic force_ref;
    } swap_ctl_t;

    // true when ones form a strict majority of total samples
    function automatic logic vote_high(input int unsigned ones, input int unsigned total);
        return (2 * ones) > total;
    endfunction

endpackage

// File: rtl/sampcal_vote.sv
module sampcal_vote
    import sampcal_pkg::*;
#(
    parameter int VOTES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic bit_i,
    output logic last_o,
    output logic high_o
);
    localparam int CW = $clog2(VOTES + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] ones;

    assign last_o = en_i && (cnt == CW'(VOTES - 1));
    assign high_o = vote_high(32'(ones) + 32'(bit_i), VOTES);

    always_ff @(posedge clk) begin
        if (rst || !en_i || last_o) begin
            cnt  <= '0;
            ones <= '0;
        end else begin
            cnt  <= cnt + CW'(1);
            ones <= ones + CW'(bit_i);
        end
    end

    // R6: a decision is taken after no more than VOTES samples
    a_r6_vote_window: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < VOTES);

endmodule

// File: rtl/sampcal_code_bank.sv
module sampcal_code_bank #(
    parameter int NUM_SAMP = 4,
    parameter int OFS_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [$clog2(NUM_SAMP)-1:0] wr_idx_i,
    input  logic [OFS_W-1:0]          wr_code_i,
    input  logic                      ovr_en_i,
    input  logic [$clog2(NUM_SAMP)-1:0] ovr_idx_i,
    input  logic [OFS_W-1:0]          ovr_code_i,
    output logic [NUM_SAMP*OFS_W-1:0] codes_o
);
    localparam int IW = $clog2(NUM_SAMP);
    localparam logic [OFS_W-1:0] MID = OFS_W'(1) << (OFS_W - 1);

    for (genvar g = 0; g < NUM_SAMP; g++) begin : g_slot
        logic [OFS_W-1:0] code_q;

        always_ff @(posedge clk) begin
            if (rst)
                code_q <= MID;
            else if (wr_en_i && wr_idx_i == IW'(g))
                code_q <= wr_code_i;
        end

        assign codes_o[g*OFS_W +: OFS_W] =
            (ovr_en_i && ovr_idx_i == IW'(g)) ? ovr_code_i : code_q;
    end

endmodule

// File: rtl/sampcal_seq.sv
module sampcal_seq
    import sampcal_pkg::*;
#(
    parameter int NUM_SAMP   = 4,
    parameter int OFS_W      = 5,
    parameter int SETTLE_CYC = 4,
    parameter int VOTES      = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic                        abort_i,
    input  logic [NUM_SAMP-1:0]         cmp_i,
    output logic [NUM_SAMP*OFS_W-1:0]   ofs_code_o,
    output logic                        sub_en_o,
    output logic [$clog2(NUM_SAMP)-1:0] sub_sel_o,
    output logic                        thr_swap_o,
    output logic                        force_ref_o,
    output logic                        busy_o,
    output logic                        done_o
);
    localparam int IW  = $clog2(NUM_SAMP);
    localparam int BW  = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam int SCW = $clog2(SETTLE_CYC + 1);
    localparam logic [OFS_W-1:0] TOP_BIT = OFS_W'(1) << (OFS_W - 1);

    cal_state_e       state;
    logic [IW-1:0]    idx;
    logic [SCW-1:0]   settle_cnt;
    logic [BW-1:0]    bpos;
    logic [OFS_W-1:0] trial;
    logic             done_q;
    swap_ctl_t        ctl;

    logic             vote_last, vote_hi;
    logic [OFS_W-1:0] bit_mask, trial_dec;
    logic             commit;

    assign bit_mask  = OFS_W'(1) << bpos;
    assign trial_dec = vote_hi ? (trial & ~bit_mask) : trial;
    assign commit    = vote_last && (bpos == '0) && !abort_i;

    sampcal_vote #(.VOTES(VOTES)) u_vote (
        .clk    (clk),
        .rst    (rst),
        .en_i   (state == ST_SEARCH),
        .bit_i  (cmp_i[idx]),
        .last_o (vote_last),
        .high_o (vote_hi)
    );

    sampcal_code_bank #(.NUM_SAMP(NUM_SAMP), .OFS_W(OFS_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (commit),
        .wr_idx_i   (idx),
        .wr_code_i  (trial_dec),
        .ovr_en_i   (ctl.force_ref),
        .ovr_idx_i  (idx),
        .ovr_code_i (trial),
        .codes_o    (ofs_code_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            idx        <= '0;
            settle_cnt <= '0;
            bpos       <= '0;
            trial      <= TOP_BIT;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort_i) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (start_i) begin
                        state      <= ST_SETTLE;
                        idx        <= '0;
                        settle_cnt <= '0;
                    end
                    ST_SETTLE: begin
                        if (settle_cnt == SCW'(SETTLE_CYC - 1)) begin
                            state <= ST_SEARCH;
                            bpos  <= BW'(OFS_W - 1);
                            trial <= TOP_BIT;
                        end else begin
                            settle_cnt <= settle_cnt + SCW'(1);
                        end
                    end
                    ST_SEARCH: if (vote_last) begin
                        if (bpos == '0) begin
                            state <= ST_RESTORE;
                        end else begin
                            trial <= trial_dec | (bit_mask >> 1);
                            bpos  <= bpos - BW'(1);
                        end
                    end
                    ST_RESTORE: begin
                        settle_cnt <= '0;
                        if (idx == IW'(NUM_SAMP - 1)) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx   <= idx + IW'(1);
                            state <= ST_SETTLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        ctl.out_swap  = (state == ST_SETTLE) || (state == ST_SEARCH);
        ctl.ref_swap  = (state == ST_SEARCH);
        ctl.force_ref = (state == ST_SEARCH);
    end

    assign sub_en_o    = ctl.out_swap;
    assign thr_swap_o  = ctl.ref_swap;
    assign force_ref_o = ctl.force_ref;
    assign sub_sel_o   = idx;
    assign busy_o      = (state != ST_IDLE);
    assign done_o      = done_q;

    // R3: forcing never starts without a swap already in place
    a_r3_swap_before_force: assert property (@(posedge clk) disable iff (rst)
        $rose(force_ref_o) |-> $past(sub_en_o));

    // R4: the output path is substituted throughout the search
    a_r4_force_under_swap: assert property (@(posedge clk) disable iff (rst)
        force_ref_o |-> sub_en_o && thr_swap_o);

    // R7: selection changes only across a released swap
    a_r7_sel_gap: assert property (@(posedge clk) disable iff (rst)
        sub_en_o && $past(sub_en_o) |-> sub_sel_o == $past(sub_sel_o));

    // R8: done is a single-cycle pulse while idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o ##1 !done_o);

    // R9: abort releases everything on the next edge
    a_r9_abort_release: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !sub_en_o && !thr_swap_o && !force_ref_o && !busy_o && !done_o);

endmodule

// File: tb/sampcal_seq_tb.sv
`timescale 1ns/1ps
module sampcal_seq_tb;
    localparam int NS = 4;
    localparam int W  = 5;
    localparam int ST = 4;
    localparam int NV = 5;

    // {noise, start_mid, t3, t2, t1, t0}
    localparam logic [21:0] VEC [0:3] = '{
        {1'b0, 1'b0, 5'd3,  5'd31, 5'd0,  5'd17},
        {1'b1, 1'b0, 5'd9,  5'd1,  5'd30, 5'd22},
        {1'b0, 1'b1, 5'd15, 5'd16, 5'd5,  5'd28},
        {1'b1, 1'b0, 5'd31, 5'd0,  5'd12, 5'd7}
    };

    logic clk = 0, rst = 1, start = 0, abort = 0;
    logic [NS-1:0]   cmp;
    logic [NS*W-1:0] ofs_bus;
    logic sub_en, thr_swap, force_ref, busy, done;
    logic [1:0] sub_sel;
    logic [W-1:0] tgt [NS];
    logic noise = 0;
    int ph = 0;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    sampcal_seq #(.NUM_SAMP(NS), .OFS_W(W), .SETTLE_CYC(ST), .VOTES(NV)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .abort_i(abort), .cmp_i(cmp),
        .ofs_code_o(ofs_bus), .sub_en_o(sub_en), .sub_sel_o(sub_sel),
        .thr_swap_o(thr_swap), .force_ref_o(force_ref), .busy_o(busy), .done_o(done)
    );

    // comparator model: 1 when code exceeds hidden offset; one vote in five flipped with noise
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            if (force_ref && sub_sel == 2'(s))
                cmp[s] = (ofs_bus[s*W +: W] > tgt[s]) ^ (noise && ph == 0);
            else
                cmp[s] = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!force_ref) ph <= 0;
        else ph <= (ph == NV - 1) ? 0 : ph + 1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int s);
        return int'(ofs_bus[s*W +: W]);
    endfunction

    task automatic run_round(input logic [21:0] v);
        int exp_sel = 0, settle = 0, n_done = 0;
        logic prev_en = 0, prev_f = 0;
        for (int s = 0; s < NS; s++) tgt[s] = v[s*W +: W];
        noise = v[21];
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 400 && n_done == 0; i++) begin
            if (v[20] && i == 40) start = 1;
            if (i == 41) start = 0;
            if (sub_en && !prev_en) begin
                check(32'(sub_sel) == exp_sel, "R2 order", sub_sel, exp_sel);
                exp_sel++;
                settle = 0;
            end
            if (sub_en && !force_ref) settle++;
            if (force_ref && !prev_f) begin
                check(settle == ST, "R3 settle", settle, ST);
                check(thr_swap && sub_en, "R4 swaps", thr_swap, 1);
            end
            if (done) begin
                n_done++;
                check(!busy, "R8 busy low at done", busy, 0);
            end
            prev_en = sub_en; prev_f = force_ref;
            @(negedge clk);
        end
        check(exp_sel == NS, "R2 one pass", exp_sel, NS);
        check(!done, "R8 pulse width", done, 0);
        for (int s = 0; s < NS; s++)
            check(code_of(s) == int'(tgt[s]), v[21] ? "R6 R7 voted code" : "R5 R7 code",
                  code_of(s), tgt[s]);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) tgt[s] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!sub_en && !thr_swap && !force_ref && !busy && !done, "R1 controls", busy, 0);
        for (int s = 0; s < NS; s++) check(code_of(s) == 16, "R1 code", code_of(s), 16);
        rst = 0;
        @(negedge clk);
        check(!busy && code_of(0) == 16, "R1 after release", code_of(0), 16);

        for (int k = 0; k < 4; k++) run_round(VEC[k]);

        // R10: abort on the final decision edge of sampler 0 (stored = 7 from last round)
        for (int s = 0; s < NS; s++) tgt[s] = 5'd22;
        noise = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (!force_ref) @(negedge clk);
        repeat (NV * W - 1) @(negedge clk);
        abort = 1;
        @(negedge clk); abort = 0;
        check(!sub_en && !thr_swap && !force_ref && !busy, "R9 release", sub_en, 0);
        check(code_of(0) == 7, "R10 code kept", code_of(0), 7);

        // R9: abort during sampler 1 keeps committed sampler 0
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (!(force_ref && sub_sel == 2'd1)) @(negedge clk);
        repeat (3) @(negedge clk);
        abort = 1;
        @(negedge clk); abort = 0;
        check(!sub_en && !busy, "R9 release mid", busy, 0);
        check(code_of(0) == 22, "R9 committed kept", code_of(0), 22);
        check(code_of(1) == 12, "R9 trial discarded", code_of(1), 12);
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                if (done || busy) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R9 no done", seen, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule